// File: doc/BRIEF.md
# Sized Add/Subtract and Decimal Adjust Unit

This unit performs the add and subtract work of a small CPU datapath. It takes a destination operand and a source operand with a size code for 8, 16 or 32 bits. It can add or subtract them with or without the incoming carry flag, and it can step a register up or down by a small constant. It also corrects a byte result into two packed BCD digits, using the carry and half-carry flags left by the preceding add or subtract. Operand fetch and addressing are handled elsewhere. The unit sees only the operand values, a flag that says whether the source came from an immediate, and the current condition flags.

Each request is a single-cycle `valid_i` strobe. One cycle later `done_o` pulses, and the registered result and flags appear with it. If an operation, size or constant combination is not allowed, the unit does not execute it. It reports `illegal_o` with the done pulse, and the result and flags keep their previous values. Result bits above the selected size are copied from the destination operand.

Flag vector layout on `flags_i` and `flags_o`: bit 0 C (carry or borrow), bit 1 V (signed overflow), bit 2 Z (zero), bit 3 N (negative), bit 4 H (half carry or borrow).

Top module: `arith_unit`

## Requirements
- R1: Operation codes 0 (add) and 1 (subtract) compute dst ± src at size code 0 (8 bit), 1 (16 bit) or 2 (32 bit). Result bits above the size are copied from dst.
- R2: For add and subtract, C is the carry or borrow out of the top bit of the size, and V is signed overflow at that size. N is the top bit of the sized result, and Z is set when the sized result is zero. H is the carry or borrow out of bit 3, 11 or 27.
- R3: Codes 2 (add with carry) and 3 (subtract with carry) also add or subtract the incoming C. Z is cleared when the sized result is nonzero and is otherwise kept from the input. All other flags follow R2.
- R4: Subtract (code 1) with `imm_i`=1 at byte size is illegal. An illegal request gives `done_o`=1 with `illegal_o`=1, and `result_o` and `flags_o` keep their previous values.
- R5: Codes 4 (increment) and 5 (decrement) change dst by 1 when `const_sel_i`=0 and by 2 when it is 1, at any of the three sizes. N, Z and V are updated as in R2, and C and H keep their input values.
- R6: Byte size with `const_sel_i`=1 is illegal for codes 4 and 5. So is any `const_sel_i` above 1.
- R7: Codes 6 (add constant) and 7 (subtract constant) change a 32-bit dst by 1, 2 or 4 for `const_sel_i` 0, 1 or 2. All flags pass through unchanged. Any other size, or `const_sel_i`=3, is illegal.
- R8: Code 8 (decimal adjust after add) works on the low byte of dst. It adds 0x60 if C is set or the byte is above 0x99, and this case also sets C. It adds 0x06 if H is set or the low nibble is above 9. Otherwise C keeps its input value.
- R9: Code 9 (decimal adjust after subtract) subtracts 0x60 if C is set and 0x06 if H is set, and C keeps its input value. For both adjust codes N and Z follow the byte result, and V and H keep their input values.
- R10: The adjust codes 8 and 9 are illegal at any size other than byte.
- R11: Size code 3 and operation codes 10 to 15 are illegal.
- R12: `done_o` pulses exactly one cycle after each `valid_i` cycle and at no other time. Back-to-back requests are accepted every cycle.
- R13: After reset `result_o`, `flags_o`, `done_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| valid_i | input | 1 | request strobe |
| op_i | input | 4 | operation code |
| size_i | input | 2 | operand size code |
| imm_i | input | 1 | source operand is an immediate |
| const_sel_i | input | 2 | constant selector (1, 2, 4) |
| dst_i | input | 32 | destination operand |
| src_i | input | 32 | source operand |
| flags_i | input | 5 | current flags {H,N,Z,V,C} |
| done_o | output | 1 | result valid pulse |
| illegal_o | output | 1 | request was rejected |
| result_o | output | 32 | registered result |
| flags_o | output | 5 | registered flags {H,N,Z,V,C} |

## Verification
Directed cases place a carry exactly at the nibble boundary, at the sign boundary and at the top of each size. These show whether H, V and C come from the correct bit for the selected size. Separate cases with a known nonzero upper dst show whether the upper result bits really pass through. With-carry cases are run twice, once with Z set and a zero result and once with a nonzero result. The two runs separate the sticky-Z rule from a plain Z update. A long random stream mixes legal and illegal combinations of operation, size and constant, and it exposes legality errors and any state change on rejected requests.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_SIZES = 3;
  localparam int DATA_W  = BYTE_W << (N_SIZES - 1);
  localparam int OP_W    = 4;
  localparam int SZ_W    = 2;
  localparam int CS_W    = 2;
  localparam int FL_W    = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0, OP_SUB  = 4'd1, OP_ADDC = 4'd2, OP_SUBC = 4'd3,
    OP_INC  = 4'd4, OP_DEC  = 4'd5, OP_ADDQ = 4'd6, OP_SUBQ = 4'd7,
    OP_DADD = 4'd8, OP_DSUB = 4'd9
  } op_e;

  localparam logic [SZ_W-1:0] SZ_B = 2'd0;
  localparam logic [SZ_W-1:0] SZ_W16 = 2'd1;
  localparam logic [SZ_W-1:0] SZ_L = 2'd2;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/arith_legal.sv
module arith_legal
  import arith_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            imm_i,
  input  logic [CS_W-1:0] cs_i,
  output logic            legal_o
);
  always_comb begin
    legal_o = (size_i != 2'd3);
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBC: ;
      OP_SUB:           if (imm_i && size_i == SZ_B) legal_o = 1'b0;
      OP_INC, OP_DEC:   if (cs_i > 2'd1 || (size_i == SZ_B && cs_i != 2'd0)) legal_o = 1'b0;
      OP_ADDQ, OP_SUBQ: if (size_i != SZ_L || cs_i == 2'd3) legal_o = 1'b0;
      OP_DADD, OP_DSUB: if (size_i != SZ_B) legal_o = 1'b0;
      default:          legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/arith_core.sv
module arith_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o,
  output logic         h_o,
  output logic         n_o,
  output logic         z_o
);
  localparam int HW = W - 4;
  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - {{HW{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
    end
    res_o = full[W-1:0];
    c_o   = full[W];
    h_o   = half[HW];
    n_o   = res_o[W-1];
    z_o   = (res_o == '0);
    // overflow: operand signs agree (add) or differ (sub) and result sign flips
    v_o   = (sub_i ? (a_i[W-1] ^ b_i[W-1]) : ~(a_i[W-1] ^ b_i[W-1]))
            & (res_o[W-1] ^ a_i[W-1]);
  end
endmodule

// File: rtl/arith_bcd.sv
module arith_bcd
  import arith_pkg::*;
(
  input  logic [BYTE_W-1:0] val_i,
  input  logic              c_i,
  input  logic              h_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              c_o
);
  logic hi_fix, lo_fix;
  logic [BYTE_W-1:0] corr;

  always_comb begin
    if (sub_i) begin
      hi_fix = c_i;
      lo_fix = h_i;
    end else begin
      hi_fix = c_i | (val_i > 8'h99);
      lo_fix = h_i | (val_i[3:0] > 4'd9);
    end
    corr  = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    res_o = sub_i ? (val_i - corr) : (val_i + corr);
    c_o   = hi_fix;
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              imm_i,
  input  logic [CS_W-1:0]   const_sel_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [FL_W-1:0]   flags_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o,
  output logic [FL_W-1:0]   flags_o
);
  op_e         op;
  flags_t      fl_in, nxt_fl;
  logic        legal, is_sub, use_cin, by_const;
  logic [DATA_W-1:0] b_opnd, nxt_res;
  logic [SZ_W-1:0]   sel;

  logic [DATA_W-1:0] mrg [N_SIZES];
  logic c_a [N_SIZES];
  logic v_a [N_SIZES];
  logic h_a [N_SIZES];
  logic n_a [N_SIZES];
  logic z_a [N_SIZES];

  logic [BYTE_W-1:0] bcd_res;
  logic              bcd_c;

  assign op       = op_e'(op_i);
  assign fl_in    = flags_t'(flags_i);
  assign is_sub   = op inside {OP_SUB, OP_SUBC, OP_DEC, OP_SUBQ};
  assign use_cin  = op inside {OP_ADDC, OP_SUBC};
  assign by_const = op inside {OP_INC, OP_DEC, OP_ADDQ, OP_SUBQ};
  assign b_opnd   = by_const ? (DATA_W'(1) << const_sel_i) : src_i;
  assign sel      = (size_i == 2'd3) ? SZ_L : size_i;

  arith_legal u_legal (
    .op_i(op_i), .size_i(size_i), .imm_i(imm_i), .cs_i(const_sel_i), .legal_o(legal)
  );

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int W = BYTE_W << g;
    logic [W-1:0] res;
    arith_core #(.W(W)) u_core (
      .a_i(dst_i[W-1:0]), .b_i(b_opnd[W-1:0]), .sub_i(is_sub),
      .cin_i(use_cin & fl_in.c), .res_o(res),
      .c_o(c_a[g]), .v_o(v_a[g]), .h_o(h_a[g]), .n_o(n_a[g]), .z_o(z_a[g])
    );
    if (W < DATA_W) begin : g_part
      assign mrg[g] = {dst_i[DATA_W-1:W], res};
    end else begin : g_full
      assign mrg[g] = res;
    end
  end

  arith_bcd u_bcd (
    .val_i(dst_i[BYTE_W-1:0]), .c_i(fl_in.c), .h_i(fl_in.h),
    .sub_i(op == OP_DSUB), .res_o(bcd_res), .c_o(bcd_c)
  );

  always_comb begin
    nxt_res = mrg[sel];
    nxt_fl  = fl_in;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nxt_fl = '{h: h_a[sel], n: n_a[sel], z: z_a[sel], v: v_a[sel], c: c_a[sel]};
      end
      OP_ADDC, OP_SUBC: begin
        nxt_fl = '{h: h_a[sel], n: n_a[sel], z: fl_in.z & z_a[sel], v: v_a[sel], c: c_a[sel]};
      end
      OP_INC, OP_DEC: begin
        nxt_fl.n = n_a[sel];
        nxt_fl.z = z_a[sel];
        nxt_fl.v = v_a[sel];
      end
      OP_DADD, OP_DSUB: begin
        nxt_res  = {dst_i[DATA_W-1:BYTE_W], bcd_res};
        nxt_fl.c = bcd_c;
        nxt_fl.n = bcd_res[BYTE_W-1];
        nxt_fl.z = (bcd_res == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= valid_i & ~legal;
      if (valid_i && legal) begin
        result_o <= nxt_res;
        flags_o  <= nxt_fl;
      end
    end
  end
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk
  import arith_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [SZ_W-1:0]   size_i,
  input logic              imm_i,
  input logic [CS_W-1:0]   const_sel_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [FL_W-1:0]   flags_i,
  input logic              done_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] result_o,
  input logic [FL_W-1:0]   flags_o
);
  AST_DONE_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o); // R12
  AST_NO_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o); // R12
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o); // R4
  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && illegal_o) |-> ($stable(result_o) && $stable(flags_o))); // R4
  AST_BYTE_SUB_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd1 && imm_i && size_i == 2'd0) |=> illegal_o); // R4
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd3) |=> illegal_o); // R11
  AST_QUICK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i inside {4'd6, 4'd7} && size_i == 2'd2 && const_sel_i != 2'd3)
    |=> (!illegal_o && flags_o == $past(flags_i))); // R7
  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0 && op_i inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd5})
    |=> (illegal_o || result_o[DATA_W-1:BYTE_W] == $past(dst_i[DATA_W-1:BYTE_W]))); // R1
endmodule

bind arith_unit arith_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
  .imm_i(imm_i), .const_sel_i(const_sel_i), .dst_i(dst_i), .flags_i(flags_i),
  .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/sim_arith_unit.sv
module sim_arith_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        imm_i = 1'b0;
  logic [1:0]  const_sel_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [4:0]  flags_i = '0;
  logic        done_o, illegal_o;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic        ill;
    logic [31:0] r;
    logic [4:0]  f;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] last_r = '0;
  logic [4:0]  last_f = '0;

  arith_unit u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // flags: [0]=C [1]=V [2]=Z [3]=N [4]=H
  function automatic void model(input logic [3:0] op, input logic [1:0] sz, input logic imm,
                                input logic [1:0] cs, input logic [31:0] d, input logic [31:0] s,
                                input logic [4:0] fl, output logic ill, output logic [31:0] r,
                                output logic [4:0] f);
    int w;
    longint mask, lmask, a, b, ci, sum, hs, rr, top;
    logic sub, fc, fv, fz, fn, fh;
    ill = (sz == 2'd3) || (op > 4'd9);
    if (op == 4'd1 && imm && sz == 2'd0) ill = 1;
    if ((op == 4'd4 || op == 4'd5) && (cs > 2'd1 || (sz == 2'd0 && cs == 2'd1))) ill = 1;
    if ((op == 4'd6 || op == 4'd7) && (sz != 2'd2 || cs == 2'd3)) ill = 1;
    if ((op == 4'd8 || op == 4'd9) && sz != 2'd0) ill = 1;
    if (ill) begin
      r = last_r; f = last_f; return;
    end
    fc = fl[0]; fv = fl[1]; fz = fl[2]; fn = fl[3]; fh = fl[4];
    if (op == 4'd8 || op == 4'd9) begin
      longint v, corr;
      logic hi, lo;
      v = longint'(d[7:0]);
      if (op == 4'd8) begin
        hi = fc || v > 'h99;
        lo = fh || (v % 16) > 9;
      end else begin
        hi = fc; lo = fh;
      end
      corr = (hi ? 'h60 : 0) + (lo ? 'h06 : 0);
      rr = (op == 4'd8) ? (v + corr) : (v - corr);
      rr = rr & 'hFF;
      r = {d[31:8], rr[7:0]};
      f = {fh, rr[7], rr == 0, fv, (op == 4'd8) ? hi : fc};
      return;
    end
    w = 8 << sz;
    mask = (64'sd1 <<< w) - 1;
    lmask = (64'sd1 <<< (w - 4)) - 1;
    a = longint'(d) & mask;
    b = (op >= 4'd4) ? (64'sd1 <<< cs) : (longint'(s) & mask);
    ci = (op == 4'd2 || op == 4'd3) ? longint'(fc) : 0;
    sub = (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7);
    if (sub) begin
      sum = a - b - ci;
      hs  = (a & lmask) - (b & lmask) - ci;
    end else begin
      sum = a + b + ci;
      hs  = (a & lmask) + (b & lmask) + ci;
    end
    rr = sum & mask;
    r = (d & ~32'(mask)) | 32'(rr);
    top = 64'sd1 <<< (w - 1);
    begin
      logic sa, sb2, sr, c, h, v;
      sa = (a & top) != 0; sb2 = (b & top) != 0; sr = (rr & top) != 0;
      c = sub ? (sum < 0) : (sum > mask);
      h = sub ? (hs < 0) : (hs > lmask);
      v = sub ? (sa != sb2 && sr != sa) : (sa == sb2 && sr != sa);
      case (op)
        4'd0, 4'd1: f = {h, sr, rr == 0, v, c};
        4'd2, 4'd3: f = {h, sr, fz && rr == 0, v, c};
        4'd4, 4'd5: f = {fh, sr, rr == 0, v, fc};
        default:    f = fl;
      endcase
    end
  endfunction

  task automatic run(input string tag, input logic [3:0] op, input logic [1:0] sz,
                     input logic imm, input logic [1:0] cs, input logic [31:0] d,
                     input logic [31:0] s, input logic [4:0] fl);
    exp_t e;
    model(op, sz, imm, cs, d, s, fl, e.ill, e.r, e.f);
    e.tag = tag;
    if (!e.ill) begin
      last_r = e.r; last_f = e.f;
    end
    sb.push_back(e);
    valid_i = 1'b1; op_i = op; size_i = sz; imm_i = imm; const_sel_i = cs;
    dst_i = d; src_i = s; flags_i = fl;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor: results become visible after the posedge following valid
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 stray done: actual done=1 expected done=0");
      end else begin
        e = sb.pop_front();
        if (illegal_o !== e.ill || result_o !== e.r || flags_o !== e.f) begin
          errors++;
          $display("FAIL %s actual ill=%0b res=%h fl=%b expected ill=%0b res=%h fl=%b",
                   e.tag, illegal_o, result_o, flags_o, e.ill, e.r, e.f);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (result_o !== '0 || flags_o !== '0 || done_o !== 1'b0 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R13 actual res=%h fl=%b done=%b ill=%b expected all zero",
               result_o, flags_o, done_o, illegal_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 R2: byte 7F+01 -> 80, V N H set; upper dst bits kept
    run("R1", 4'd0, 2'd0, 0, 0, 32'hABCD_127F, 32'h0000_0001, 5'b00000);
    run("R2", 4'd0, 2'd1, 0, 0, 32'h5555_FFFF, 32'h0000_0001, 5'b00000);
    run("R2", 4'd1, 2'd2, 0, 0, 32'h0000_0000, 32'h0000_0001, 5'b00000);
    run("R2", 4'd1, 2'd0, 0, 0, 32'h0000_0080, 32'h0000_0001, 5'b00000);
    run("R1", 4'd1, 2'd1, 1, 0, 32'h1234_0100, 32'h0000_0001, 5'b11111);
    // R3: zero result keeps Z, nonzero clears it; carry enters the sum
    run("R3", 4'd2, 2'd0, 0, 0, 32'h0000_00FF, 32'h0000_0000, 5'b00101);
    run("R3", 4'd2, 2'd1, 0, 0, 32'h0000_0001, 32'h0000_0001, 5'b00101);
    run("R3", 4'd3, 2'd2, 0, 0, 32'h0000_0001, 32'h0000_0000, 5'b00101);
    run("R3", 4'd3, 2'd2, 0, 0, 32'h0000_0001, 32'h0000_0000, 5'b00001);
    // R4: byte subtract of immediate rejected, state held
    run("R4", 4'd1, 2'd0, 1, 0, 32'h0000_0010, 32'h0000_0001, 5'b00000);
    // R5 R6
    run("R5", 4'd4, 2'd0, 0, 0, 32'hFFFF_FF7F, 32'h0, 5'b10001);
    run("R5", 4'd5, 2'd1, 0, 1, 32'h0000_0001, 32'h0, 5'b00000);
    run("R5", 4'd4, 2'd2, 0, 1, 32'hFFFF_FFFE, 32'h0, 5'b00000);
    run("R6", 4'd4, 2'd0, 0, 1, 32'h0000_0001, 32'h0, 5'b00000);
    run("R6", 4'd5, 2'd1, 0, 2, 32'h0000_0001, 32'h0, 5'b00000);
    // R7
    run("R7", 4'd6, 2'd2, 0, 2, 32'hFFFF_FFFE, 32'h0, 5'b01010);
    run("R7", 4'd7, 2'd2, 0, 0, 32'h0000_0000, 32'h0, 5'b10100);
    run("R7", 4'd6, 2'd1, 0, 0, 32'h0000_0000, 32'h0, 5'b00000);
    run("R7", 4'd7, 2'd2, 0, 3, 32'h0000_0008, 32'h0, 5'b00000);
    // R8 R9 R10
    run("R8", 4'd8, 2'd0, 0, 0, 32'h0000_009A, 32'h0, 5'b00000);
    run("R8", 4'd8, 2'd0, 0, 0, 32'h0000_0012, 32'h0, 5'b10000);
    run("R8", 4'd8, 2'd0, 0, 0, 32'h0000_0045, 32'h0, 5'b00010);
    run("R9", 4'd9, 2'd0, 0, 0, 32'h0000_00FA, 32'h0, 5'b10001);
    run("R9", 4'd9, 2'd0, 0, 0, 32'h0000_0033, 32'h0, 5'b00010);
    run("R10", 4'd8, 2'd1, 0, 0, 32'h0000_0099, 32'h0, 5'b00000);
    // R11
    run("R11", 4'd0, 2'd3, 0, 0, 32'h1, 32'h1, 5'b00000);
    run("R11", 4'd12, 2'd0, 0, 0, 32'h1, 32'h1, 5'b00000);
    // R12: idle gap then random back-to-back stream
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 600; i++) begin
      run("R12", 4'($urandom % 11), 2'($urandom), 1'($urandom), 2'($urandom),
          $urandom, $urandom, 5'($urandom));
    end
    repeat (3) @(negedge clk_i);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R12 missing done: actual pending=%0d expected 0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule